// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits between two independent access ports (left and right) and a true dual-port RAM. Each port presents an address, an enable and a write strobe. When both ports are enabled on the same address, the block grants the location to the port that got there first and raises an active-low hold to the other port. The write strobe passed on to the RAM for a held port is suppressed, so the location keeps its contents. Reads from a held port still reach the RAM. Their data may be stale, but they are not blocked.

A mode input chooses between two roles. In lead mode the block arbitrates and drives its hold outputs. In follower mode the hold outputs stay inactive and the hold inputs decide which writes are suppressed. Several instances can then be wired side by side to build a wider word: one instance in lead mode drives the hold inputs of the followers, and every slice blocks the same write in the same cycle.

The design uses one clock. A collision is registered, so a hold appears one cycle after the address match. While the match persists the hold stays on, and it clears one cycle after the match ends. When both ports start on the same address in the same cycle, the left port wins.

Top module: `dpca_top`

## Requirements
- R1: After reset, with no collision, both hold outputs are high (inactive).
- R2: In lead mode, if in the previous cycle the ports were not both enabled on equal addresses, both hold outputs are high in the current cycle.
- R3: In lead mode, if both ports start on the same address in the same cycle, the right hold output goes low one cycle later and the left hold output stays high.
- R4: In lead mode, if the right port was already enabled on an address in the previous cycle and the left port now enables the same address, the left hold output goes low one cycle later.
- R5: In lead mode, a hold stays low for every cycle in which the collision still existed in the previous cycle.
- R6: A hold clears one cycle after the collision ends, whether the winner disables or the addresses diverge.
- R7: In lead mode the write strobe to the RAM for a port is enable AND write AND that port's hold output. A held port's write is therefore suppressed.
- R8: The read strobe to the RAM for a port is enable AND NOT write, in every mode and whatever the hold state.
- R9: In follower mode both hold outputs stay high, and a port's write strobe to the RAM is suppressed exactly when that port's hold input is low.
- R10: In lead mode the hold inputs have no effect on the write strobes.
- R11: The two hold outputs are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| is_lead | input | 1 | 1 = lead (arbitrating) mode, 0 = follower mode |
| l_addr | input | ADDR_W | Left port address |
| l_en | input | 1 | Left port access enable |
| l_we | input | 1 | Left port write (1) / read (0) |
| l_hold_in_n | input | 1 | Left hold from a lead instance, used in follower mode |
| r_addr | input | ADDR_W | Right port address |
| r_en | input | 1 | Right port access enable |
| r_we | input | 1 | Right port write (1) / read (0) |
| r_hold_in_n | input | 1 | Right hold from a lead instance, used in follower mode |
| l_hold_n | output | 1 | Left hold, active low |
| r_hold_n | output | 1 | Right hold, active low |
| l_ram_we | output | 1 | Gated write strobe to the RAM, left port |
| l_ram_re | output | 1 | Read strobe to the RAM, left port |
| r_ram_we | output | 1 | Gated write strobe to the RAM, right port |
| r_ram_re | output | 1 | Read strobe to the RAM, right port |

## Verification
A wrong owner register shows up one cycle after a collision. The hold may land on the wrong port or on neither port, and the write strobe of a port that should have been stopped passes through to the RAM. A stale owner shows up as a hold that outlives the collision by more than one cycle. A bad history register shows up only when the ports arrive in different cycles, as a reversed winner. The sweep therefore covers every address pair, both arrival orders, long holds, both ways a collision can end, and every hold-input pattern in both modes.

// File: rtl/dpca_pkg.sv
package dpca_pkg;
   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_LEFT  = 2'd1,
      OWN_RIGHT = 2'd2
   } owner_e;

   localparam int unsigned NPORT = 2;
   localparam int unsigned PIDX_L = 0;
   localparam int unsigned PIDX_R = 1;

   // Owner value that means "the port with this index holds the location".
   function automatic owner_e owner_of(input int unsigned idx);
      return (idx == PIDX_L) ? OWN_LEFT : OWN_RIGHT;
   endfunction
endpackage

// File: rtl/dpca_port_track.sv
// Remembers the last cycle's access of one port so that a newcomer can be
// told apart from a port that was already sitting on the contested address.
module dpca_port_track #(
   parameter int unsigned ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              en,
   output logic              stayed
);
   logic              en_q;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         addr_q <= '0;
      end else begin
         en_q   <= en;
         addr_q <= addr;
      end
   end

   assign stayed = en_q && en && (addr_q == addr);
endmodule

// File: rtl/dpca_owner_fsm.sv
module dpca_owner_fsm
   import dpca_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   clash,
   input  logic   l_stayed,
   input  logic   r_stayed,
   output owner_e owner
);
   owner_e owner_q, owner_d;

   always_comb begin
      if (!clash)
         owner_d = OWN_NONE;
      else if (owner_q != OWN_NONE)
         owner_d = owner_q;
      else if (r_stayed && !l_stayed)
         owner_d = OWN_RIGHT;
      else
         owner_d = OWN_LEFT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) owner_q <= OWN_NONE;
      else        owner_q <= owner_d;
   end

   assign owner = owner_q;
endmodule

// File: rtl/dpca_port_gate.sv
module dpca_port_gate
   import dpca_pkg::*;
#(
   parameter int unsigned PIDX = 0
) (
   input  owner_e owner,
   input  logic   is_lead,
   input  logic   hold_in_n,
   input  logic   en,
   input  logic   we,
   output logic   hold_n,
   output logic   ram_we,
   output logic   ram_re
);
   localparam owner_e RIVAL = owner_of(NPORT - 1 - PIDX);

   logic lost;
   logic blocked;

   assign lost    = (owner == RIVAL);
   assign hold_n  = !(is_lead && lost);
   assign blocked = is_lead ? lost : !hold_in_n;
   assign ram_we  = en && we && !blocked;
   assign ram_re  = en && !we;
endmodule

// File: rtl/dpca_top.sv
module dpca_top
   import dpca_pkg::*;
#(
   parameter int unsigned ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              is_lead,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic              l_en,
   input  logic              l_we,
   input  logic              l_hold_in_n,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic              r_en,
   input  logic              r_we,
   input  logic              r_hold_in_n,
   output logic              l_hold_n,
   output logic              r_hold_n,
   output logic              l_ram_we,
   output logic              l_ram_re,
   output logic              r_ram_we,
   output logic              r_ram_re
);
   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_width
      $error("dpca_top: ADDR_W must be between 1 and 32");
   end

   logic [ADDR_W-1:0] p_addr   [NPORT];
   logic              p_en     [NPORT];
   logic              p_we     [NPORT];
   logic              p_hin_n  [NPORT];
   logic              p_stay   [NPORT];
   logic              p_hold_n [NPORT];
   logic              p_wr     [NPORT];
   logic              p_rd     [NPORT];
   logic              clash;
   owner_e            owner;

   assign p_addr[PIDX_L]  = l_addr;
   assign p_addr[PIDX_R]  = r_addr;
   assign p_en[PIDX_L]    = l_en;
   assign p_en[PIDX_R]    = r_en;
   assign p_we[PIDX_L]    = l_we;
   assign p_we[PIDX_R]    = r_we;
   assign p_hin_n[PIDX_L] = l_hold_in_n;
   assign p_hin_n[PIDX_R] = r_hold_in_n;

   assign clash = l_en && r_en && (l_addr == r_addr);

   for (genvar i = 0; i < NPORT; i++) begin : g_port
      dpca_port_track #(.ADDR_W(ADDR_W)) u_track (
         .clk    (clk),
         .rst_n  (rst_n),
         .addr   (p_addr[i]),
         .en     (p_en[i]),
         .stayed (p_stay[i])
      );

      dpca_port_gate #(.PIDX(i)) u_gate (
         .owner     (owner),
         .is_lead   (is_lead),
         .hold_in_n (p_hin_n[i]),
         .en        (p_en[i]),
         .we        (p_we[i]),
         .hold_n    (p_hold_n[i]),
         .ram_we    (p_wr[i]),
         .ram_re    (p_rd[i])
      );
   end

   dpca_owner_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .clash    (clash),
      .l_stayed (p_stay[PIDX_L]),
      .r_stayed (p_stay[PIDX_R]),
      .owner    (owner)
   );

   assign l_hold_n = p_hold_n[PIDX_L];
   assign r_hold_n = p_hold_n[PIDX_R];
   assign l_ram_we = p_wr[PIDX_L];
   assign r_ram_we = p_wr[PIDX_R];
   assign l_ram_re = p_rd[PIDX_L];
   assign r_ram_re = p_rd[PIDX_R];
endmodule

// File: rtl/dpca_top_chk.sv
module dpca_top_chk #(
   parameter int unsigned ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              is_lead,
   input logic [ADDR_W-1:0] l_addr,
   input logic              l_en,
   input logic              l_we,
   input logic              l_hold_in_n,
   input logic [ADDR_W-1:0] r_addr,
   input logic              r_en,
   input logic              r_we,
   input logic              r_hold_in_n,
   input logic              l_hold_n,
   input logic              r_hold_n,
   input logic              l_ram_we,
   input logic              l_ram_re,
   input logic              r_ram_we,
   input logic              r_ram_re
);
   logic hit;
   assign hit = l_en && r_en && (l_addr == r_addr);

   // R11
   one_loser_chk: assert property (@(posedge clk) disable iff (!rst_n)
      l_hold_n || r_hold_n);

   // R2
   no_clash_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_lead && !$past(hit)) |-> (l_hold_n && r_hold_n));

   // R3
   clash_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_lead && $past(is_lead) && $past(hit) && $past(l_hold_n && r_hold_n))
      |-> (!l_hold_n || !r_hold_n));

   // R5
   hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_lead && $past(is_lead) && $past(hit) && $past(!r_hold_n)) |-> !r_hold_n);

   // R7
   held_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_lead && (!l_hold_n || !l_en || !l_we)) |-> !l_ram_we);

   // R9
   follow_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !is_lead |-> (l_hold_n && r_hold_n && (r_ram_we == (r_en && r_we && r_hold_in_n))));

   // R8
   read_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (l_ram_re == (l_en && !l_we)) && (r_ram_re == (r_en && !r_we)));
endmodule

bind dpca_top dpca_top_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dpca_top_test.sv
`timescale 1ns/1ps
module dpca_top_test;
   localparam int AW = 3;
   localparam int NA = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic is_lead = 1'b1;
   logic [AW-1:0] l_addr = '0, r_addr = '0;
   logic l_en = 0, l_we = 0, r_en = 0, r_we = 0;
   logic l_hold_in_n = 1, r_hold_in_n = 1;
   logic l_hold_n, r_hold_n, l_ram_we, l_ram_re, r_ram_we, r_ram_re;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   dpca_top #(.ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .is_lead(is_lead),
      .l_addr(l_addr), .l_en(l_en), .l_we(l_we), .l_hold_in_n(l_hold_in_n),
      .r_addr(r_addr), .r_en(r_en), .r_we(r_we), .r_hold_in_n(r_hold_in_n),
      .l_hold_n(l_hold_n), .r_hold_n(r_hold_n),
      .l_ram_we(l_ram_we), .l_ram_re(l_ram_re),
      .r_ram_we(r_ram_we), .r_ram_re(r_ram_re)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   // advance to the next falling edge, apply inputs there, then let them settle
   task automatic drive(input logic le, input logic lw, input int la,
                        input logic re, input logic rw, input int ra);
      @(negedge clk);
      l_en = le; l_we = lw; l_addr = AW'(la);
      r_en = re; r_we = rw; r_addr = AW'(ra);
      #1;
   endtask

   task automatic idle();
      drive(0, 0, 0, 0, 0, 0);
   endtask

   initial begin : watchdog
      #1000000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      #1;
      chk("R1", "l_hold_n in reset", l_hold_n, 1'b1);
      chk("R1", "r_hold_n in reset", r_hold_n, 1'b1);
      rst_n = 1'b1;
      idle();
      chk("R1", "l_hold_n after reset", l_hold_n, 1'b1);
      chk("R1", "r_hold_n after reset", r_hold_n, 1'b1);

      // simultaneous arrival sweep over every address pair, both writing
      for (int la = 0; la < NA; la++) begin
         for (int ra = 0; ra < NA; ra++) begin
            idle();
            drive(1, 1, la, 1, 1, ra);
            chk("R2", "first cycle l_hold_n", l_hold_n, 1'b1);
            chk("R2", "first cycle r_hold_n", r_hold_n, 1'b1);
            chk("R7", "first cycle l_ram_we", l_ram_we, 1'b1);
            drive(1, 1, la, 1, 1, ra);
            chk("R3", "l_hold_n", l_hold_n, 1'b1);
            chk("R3", "r_hold_n", r_hold_n, (la == ra) ? 1'b0 : 1'b1);
            chk("R7", "l_ram_we", l_ram_we, 1'b1);
            chk("R7", "r_ram_we", r_ram_we, (la == ra) ? 1'b0 : 1'b1);
            if (la == ra) begin
               // winner ends; hold still shown this cycle, gone on the next
               drive(0, 0, la, 1, 1, ra);
               chk("R5", "r_hold_n one cycle after winner stops", r_hold_n, 1'b0);
               drive(0, 0, la, 1, 1, ra);
               chk("R6", "r_hold_n after winner stopped", r_hold_n, 1'b1);
               chk("R7", "r_ram_we after release", r_ram_we, 1'b1);
            end
         end
      end

      // late arrival of the left port; right keeps reading
      for (int a = 0; a < NA; a++) begin
         idle();
         drive(0, 0, 0, 1, 0, a);
         drive(1, 1, a, 1, 0, a);
         chk("R2", "late arrival first cycle l_hold_n", l_hold_n, 1'b1);
         for (int k = 0; k < 5; k++) begin
            drive(1, 1, a, 1, 0, a);
            chk("R4", "late left l_hold_n", l_hold_n, 1'b0);
            chk("R4", "late left r_hold_n", r_hold_n, 1'b1);
            chk("R5", "l_ram_we while held", l_ram_we, 1'b0);
            chk("R8", "r_ram_re of winner", r_ram_re, 1'b1);
         end
         // addresses diverge
         drive(1, 1, a, 1, 0, (a + 1) % NA);
         chk("R5", "hold in divergence cycle", l_hold_n, 1'b0);
         drive(1, 1, a, 1, 0, (a + 1) % NA);
         chk("R6", "l_hold_n after divergence", l_hold_n, 1'b1);
         chk("R7", "l_ram_we after divergence", l_ram_we, 1'b1);
      end

      // held port reading still reaches the RAM
      idle();
      drive(1, 1, 2, 1, 0, 2);
      drive(1, 1, 2, 1, 0, 2);
      chk("R8", "held right read l_hold", r_hold_n, 1'b0);
      chk("R8", "held right r_ram_re", r_ram_re, 1'b1);
      chk("R8", "held right r_ram_we", r_ram_we, 1'b0);

      // R10: hold inputs ignored in lead mode
      idle();
      l_hold_in_n = 0; r_hold_in_n = 0;
      drive(1, 1, 1, 1, 1, 4);
      chk("R10", "l_ram_we with hold inputs low", l_ram_we, 1'b1);
      chk("R10", "r_ram_we with hold inputs low", r_ram_we, 1'b1);
      drive(1, 1, 1, 1, 1, 4);
      chk("R10", "l_hold_n with hold inputs low", l_hold_n, 1'b1);

      // R9: follower mode, every hold-input pattern, colliding writes
      is_lead = 0;
      for (int p = 0; p < 4; p++) begin
         l_hold_in_n = p[0]; r_hold_in_n = p[1];
         idle();
         drive(1, 1, 3, 1, 1, 3);
         drive(1, 1, 3, 1, 1, 3);
         chk("R9", "follower l_hold_n", l_hold_n, 1'b1);
         chk("R9", "follower r_hold_n", r_hold_n, 1'b1);
         chk("R9", "follower l_ram_we", l_ram_we, p[0] ? 1'b1 : 1'b0);
         chk("R9", "follower r_ram_we", r_ram_we, p[1] ? 1'b1 : 1'b0);
         drive(1, 0, 3, 1, 0, 3);
         chk("R8", "follower l_ram_re", l_ram_re, 1'b1);
      end
      l_hold_in_n = 1; r_hold_in_n = 1;
      is_lead = 1;
      idle();
      idle();

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end
endmodule